// File: doc/BRIEF.md
# Three-Share Masked AND Gate

This block computes a bitwise AND of two secret operands, x and y, without the plain values ever appearing on a wire. Each operand arrives as three shares whose XOR is the secret value. The block forms three output shares whose XOR is x AND y. Each output share is built from only two of the three share indices of each input, so no single share function can see a whole secret. That property is what limits first-order power leakage when glitches occur.

The share products are registered before anything else combines them, so each clock cycle has only one level of nonlinear logic. A second register stage then adds fresh random bits to the shares. This restores a uniform output sharing and leaves the XOR of the shares unchanged. The lane width W is a parameter: the block holds W independent gates side by side and takes 2*W random bits with each operation. A valid bit travels with the data. Results appear a fixed two cycles after the inputs and hold until the next operation. The random source and any datapath around the gate are outside the block.

Top module: `ti_and3`

## Requirements
- R1: Output share i never depends on input share i of x or of y. The indices are 0, 1 and 2, and share i appears on port z<i>, x<i> and y<i>. With both random halves at zero, changing x<i> and y<i> leaves z<i> unchanged.
- R2: For every input and random value, z0 ^ z1 ^ z2 equals (x0 ^ x1 ^ x2) & (y0 ^ y1 ^ y2), bit by bit.
- R3: With j = (i+1) mod 3 and k = (i+2) mod 3, the unmasked share i is s_i = (xj & yj) ^ (xj & yk) ^ (xk & yj).
- R4: The random input is split into two halves, r0 = rnd[W-1:0] and r1 = rnd[2W-1:W]. Both halves are captured together with the operands. The outputs are z0 = s0 ^ r0, z1 = s1 ^ r1 and z2 = s2 ^ r0 ^ r1.
- R5: out_valid goes high exactly two rising edges after in_valid is sampled high, for one cycle for each accepted input. At all other times it stays low.
- R6: A cycle with in_valid low loads nothing. The output shares keep their last values, whatever the share and random inputs do.
- R7: A synchronous active-high rst clears all pipeline registers. After reset, out_valid and all output shares are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input shares and random bits are valid this cycle |
| x0 | input | W | Share 0 of operand x |
| x1 | input | W | Share 1 of operand x |
| x2 | input | W | Share 2 of operand x |
| y0 | input | W | Share 0 of operand y |
| y1 | input | W | Share 1 of operand y |
| y2 | input | W | Share 2 of operand y |
| rnd | input | 2*W | Fresh random bits: r0 in the low half, r1 in the high half |
| out_valid | output | 1 | Output shares hold a new result this cycle |
| z0 | output | W | Output share 0 |
| z1 | output | W | Output share 1 |
| z2 | output | W | Output share 2 |

## Verification
The bound checker watches four behaviours on every cycle:
- the XOR of the output shares equals the AND of the operands unmasked two cycles earlier;
- the valid bit lands exactly two edges later;
- the outputs stay frozen after a cycle with no valid input;
- reset clears everything.

Correctness alone cannot show non-completeness or the exact form of each share, because a design that mixes up share indices can still XOR to the right value. The bench therefore compares each output share against the share formula and the remask rule. It also alters one index of both inputs and confirms that the matching output share does not move.

// File: rtl/ti_and3_pkg.sv
package ti_and3_pkg;
   localparam int NSHARE = 3;

   function automatic int rot(input int i, input int d);
      return (i + d) % NSHARE;
   endfunction
endpackage

// File: rtl/ti_share_fn.sv
module ti_share_fn #(
   parameter int W = 8
) (
   input  logic [W-1:0] xj,
   input  logic [W-1:0] xk,
   input  logic [W-1:0] yj,
   input  logic [W-1:0] yk,
   output logic [W-1:0] s
);
   // single nonlinear level: three ANDs folded by XOR
   always_comb s = (xj & yj) ^ (xj & yk) ^ (xk & yj);
endmodule

// File: rtl/ti_remask.sv
module ti_remask #(
   parameter int W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ld,
   input  logic [2:0][W-1:0]   sh,
   input  logic [W-1:0]        r0,
   input  logic [W-1:0]        r1,
   output logic [2:0][W-1:0]   z,
   output logic                vld
);
   logic [2:0][W-1:0] mask;

   always_comb begin
      mask[0] = r0;
      mask[1] = r1;
      mask[2] = r0 ^ r1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         z   <= '0;
         vld <= 1'b0;
      end else begin
         vld <= ld;
         if (ld) z <= sh ^ mask;
      end
   end
endmodule

// File: rtl/ti_and3.sv
module ti_and3
   import ti_and3_pkg::*;
#(
   parameter int W = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   input  logic [W-1:0]   x0,
   input  logic [W-1:0]   x1,
   input  logic [W-1:0]   x2,
   input  logic [W-1:0]   y0,
   input  logic [W-1:0]   y1,
   input  logic [W-1:0]   y2,
   input  logic [2*W-1:0] rnd,
   output logic           out_valid,
   output logic [W-1:0]   z0,
   output logic [W-1:0]   z1,
   output logic [W-1:0]   z2
);
   localparam int RW = 2 * W;

   if (W < 1) begin : g_bad_width
      $error("ti_and3: W must be at least 1");
   end

   logic [NSHARE-1:0][W-1:0] xs, ys, sh_d, sh_q, zq;
   logic [RW-1:0]            rnd_q;
   logic                     v1_q;

   assign xs = {x2, x1, x0};
   assign ys = {y2, y1, y0};

   // share i sees only indices i+1 and i+2
   for (genvar i = 0; i < NSHARE; i++) begin : g_share
      ti_share_fn #(.W(W)) u_fn (
         .xj (xs[rot(i, 1)]),
         .xk (xs[rot(i, 2)]),
         .yj (ys[rot(i, 1)]),
         .yk (ys[rot(i, 2)]),
         .s  (sh_d[i])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= '0;
         rnd_q <= '0;
         v1_q  <= 1'b0;
      end else begin
         v1_q <= in_valid;
         if (in_valid) begin
            sh_q  <= sh_d;
            rnd_q <= rnd;
         end
      end
   end

   ti_remask #(.W(W)) u_remask (
      .clk (clk),
      .rst (rst),
      .ld  (v1_q),
      .sh  (sh_q),
      .r0  (rnd_q[W-1:0]),
      .r1  (rnd_q[RW-1:W]),
      .z   (zq),
      .vld (out_valid)
   );

   assign z0 = zq[0];
   assign z1 = zq[1];
   assign z2 = zq[2];
endmodule

// File: rtl/ti_and3_chk.sv
module ti_and3_chk #(
   parameter int W = 8
) (
   input logic           clk,
   input logic           rst,
   input logic           in_valid,
   input logic [W-1:0]   x0,
   input logic [W-1:0]   x1,
   input logic [W-1:0]   x2,
   input logic [W-1:0]   y0,
   input logic [W-1:0]   y1,
   input logic [W-1:0]   y2,
   input logic           out_valid,
   input logic [W-1:0]   z0,
   input logic [W-1:0]   z1,
   input logic [W-1:0]   z2
);
   logic [W-1:0] xu, yu, zu;
   assign xu = x0 ^ x1 ^ x2;
   assign yu = y0 ^ y1 ^ y2;
   assign zu = z0 ^ z1 ^ z2;

   p_correct_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##2 (zu == $past(xu & yu, 2)));

   p_lat_hi_r5: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##2 out_valid);

   p_lat_lo_r5: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> ##2 !out_valid);

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> ##2 $stable({z0, z1, z2}));

   p_reset_clear_r7: assert property (@(posedge clk)
      rst |=> (!out_valid && z0 == '0 && z1 == '0 && z2 == '0));
endmodule

bind ti_and3 ti_and3_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .x0        (x0),
   .x1        (x1),
   .x2        (x2),
   .y0        (y0),
   .y1        (y1),
   .y2        (y2),
   .out_valid (out_valid),
   .z0        (z0),
   .z1        (z1),
   .z2        (z2)
);

// File: tb/sim_ti_and3.sv
`timescale 1ns/1ps
module sim_ti_and3;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           in_valid = 1'b0;
   logic [W-1:0]   x0 = '0, x1 = '0, x2 = '0, y0 = '0, y1 = '0, y2 = '0;
   logic [2*W-1:0] rnd = '0;
   logic           out_valid;
   logic [W-1:0]   z0, z1, z2;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   ti_and3 #(.W(W)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .x0(x0), .x1(x1), .x2(x2), .y0(y0), .y1(y1), .y2(y2),
      .rnd(rnd), .out_valid(out_valid), .z0(z0), .z1(z1), .z2(z2)
   );

   // {x0,x1,x2,y0,y1,y2,rnd}
   localparam logic [63:0] VEC [8] = '{
      64'h00_00_00_00_00_00_0000,
      64'hFF_00_00_FF_00_00_0000,
      64'h12_34_56_9A_BC_DE_0000,
      64'hA5_5A_FF_0F_F0_33_0000,
      64'hFF_FF_FF_FF_FF_FF_FFFF,
      64'h3C_C3_81_7E_18_E7_5AA5,
      64'h01_80_7F_FE_02_40_1234,
      64'hDE_AD_BE_EF_CA_FE_F00D
   };

   function automatic logic [W-1:0] sfn(input logic [W-1:0] xj, xk, yj, yk);
      return (xj & yj) ^ (xj & yk) ^ (xk & yj);
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one accepted operation; returns output shares two edges later
   task automatic op(input logic [W-1:0] a0, a1, a2, b0, b1, b2,
                     input logic [2*W-1:0] r,
                     output logic [W-1:0] o0, o1, o2);
      @(negedge clk);
      x0 = a0; x1 = a1; x2 = a2; y0 = b0; y1 = b1; y2 = b2; rnd = r;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      x0 = ~a0; y1 = ~b1; rnd = ~r;
      chk("R5 valid low after one edge", {7'd0, out_valid}, 8'd0);
      @(negedge clk);
      chk("R5 valid high after two edges", {7'd0, out_valid}, 8'd1);
      o0 = z0; o1 = z1; o2 = z2;
      @(negedge clk);
      chk("R5 valid single cycle", {7'd0, out_valid}, 8'd0);
   endtask

   initial begin : watchdog
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] o0, o1, o2, e0, e1, e2, r0, r1, h0, h1, h2;
      logic [W-1:0] a0, a1, a2, b0, b1, b2;
      repeat (3) @(negedge clk);
      chk("R7 reset out_valid", {7'd0, out_valid}, 8'd0);
      chk("R7 reset z0", z0, '0);
      chk("R7 reset z1", z1, '0);
      chk("R7 reset z2", z2, '0);
      rst = 1'b0;

      for (int v = 0; v < 8; v++) begin
         {a0, a1, a2, b0, b1, b2, r1, r0} = VEC[v];
         op(a0, a1, a2, b0, b1, b2, {r1, r0}, o0, o1, o2);
         e0 = sfn(a1, a2, b1, b2) ^ r0;
         e1 = sfn(a2, a0, b2, b0) ^ r1;
         e2 = sfn(a0, a1, b0, b1) ^ r0 ^ r1;
         chk("R3/R4 share z0", o0, e0);
         chk("R3/R4 share z1", o1, e1);
         chk("R3/R4 share z2", o2, e2);
         chk("R2 unmasked AND", o0 ^ o1 ^ o2, (a0 ^ a1 ^ a2) & (b0 ^ b1 ^ b2));
      end

      // R1: with zero randomness, flipping share i of both inputs leaves z<i>
      for (int i = 0; i < 3; i++) begin
         op(8'h6B, 8'h2D, 8'hC4, 8'h93, 8'h5E, 8'h71, '0, o0, o1, o2);
         op(i == 0 ? 8'h94 : 8'h6B, i == 1 ? 8'hD2 : 8'h2D, i == 2 ? 8'h3B : 8'hC4,
            i == 0 ? 8'h6C : 8'h93, i == 1 ? 8'hA1 : 8'h5E, i == 2 ? 8'h8E : 8'h71,
            '0, h0, h1, h2);
         case (i)
            0: chk("R1 z0 ignores x0,y0", h0, o0);
            1: chk("R1 z1 ignores x1,y1", h1, o1);
            default: chk("R1 z2 ignores x2,y2", h2, o2);
         endcase
      end

      // R6: inputs churn with in_valid low; outputs must hold
      op(8'h11, 8'h22, 8'h44, 8'h88, 8'h0F, 8'hF0, 16'hBEEF, o0, o1, o2);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         x0 = 8'(c * 37); x2 = 8'hFF; y2 = 8'(c); rnd = 16'hFFFF;
      end
      @(negedge clk);
      chk("R6 hold z0", z0, o0);
      chk("R6 hold z1", z1, o1);
      chk("R6 hold z2", z2, o2);
      chk("R6 no valid", {7'd0, out_valid}, 8'd0);

      // R7: mid-run reset clears loaded state
      @(negedge clk);
      x0 = 8'hFF; x1 = 8'h00; x2 = 8'h00; y0 = 8'hFF; y1 = 8'h00; y2 = 8'h00;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R7 mid reset out_valid", {7'd0, out_valid}, 8'd0);
      chk("R7 mid reset z", z0 | z1 | z2, '0);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 no stale valid", {7'd0, out_valid}, 8'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule